// File: doc/BRIEF.md
# DC-Link Balancing Commutation Selector

This block drives the modulator of a three-cell cascaded H-bridge stack. Once per sampling period the controller presents a snapshot and pulses `start`. The snapshot holds the measured capacitor voltage of each cell, the AC line current, the averaged converter voltage demand, each cell's present state, and the device forward drops and on-resistances. The block answers with a single command: which cell commutates, the state it moves to, and the tick within the period at which it switches. It can also answer that no cell commutates. Only one cell changes per period, and only to an adjacent level, so each period has at most one switching edge.

Candidate cells are tried in order of how far each capacitor sits from the stack mean. A candidate is accepted only if the current direction means its move will not widen that imbalance. Before the switching instant is computed, the voltage each cell really produces is corrected for its device drops and resistive losses. The instant is the result of one multi-cycle restoring division by the selected cell's capacitor voltage. The command is ready a few tens of cycles after `start`.

Top module: `dclink_commutation_selector`

## Requirements
- R1: While reset is held and after it is released, `done` and `cmd_valid` are 0, and `cmd_cell`, `cmd_state` and `cmd_tx` are 0.
- R2: Each cell has an imbalance E = S − 3·Vdc, where S is the sum of the three capacitor voltages. This is the cell's error from the mean, scaled by three. Cells are tried in descending order of |E|, and on a tie the lower index is tried first. The command reports the first candidate that is allowed. A cell "agrees" with the current when (E ≥ 0) equals (I ≥ 0).
- R3: The loss terms are computed as follows, with shifts rounding toward minus infinity and R holding RF fractional bits. Z = sgn(I)·(Vd+Vq) − (I·(Rd+Rq) >> RF). P = −2·(Vq + (|I|·Rq >> RF)). M = 2·(Vd + (|I|·Rd >> RF)). A cell in state 0 produces Z. A cell in state s ≠ 0 produces Vdc+P when (s > 0) equals (I ≥ 0), and Vdc+M otherwise. For a candidate k, the demand is D = Vref − Σ(other cells' state × produced voltage), plus Z when k is in state 0. The normalizer N is Vdc[k] when k is in state 0, and k's produced voltage otherwise. A candidate with Vdc ≤ 0 or N ≤ 0 is never allowed.
- R4: When D > 0, the allowed moves are these. −1→0 when the cell agrees, with X = 0. 0→+1 when the cell agrees, with X = Vdc − D + (P if I < 0, else M). +1→0 when the cell does not agree and D < N, with X = D − Z.
- R5: When D < 0, the allowed moves are these. +1→0 when the cell does not agree, with X = 0. 0→−1 when the cell does not agree, with X = Vdc + D − (M if I < 0, else P). −1→0 when the cell agrees and D > −N, with X = Z − D. When D = 0, no move is allowed.
- R6: If no candidate is allowed, `done` comes with `cmd_valid` = 0, `cmd_cell` = 0, `cmd_state` = 0 and `cmd_tx` = 0.
- R7: `cmd_tx` is 0 when X ≤ 0 and TM when X ≥ Vdc[k]. Otherwise it is floor(TM·X / Vdc[k]), so it always lies in 0..TM.
- R8: `done` is high for exactly one cycle, at most NCELL + NW + 4 cycles after the accepted `start`, where NW = VW − 1 + clog2(TM+1). A `start` that arrives before `done` is ignored. The command outputs stay valid from `done` until the next accepted `start`.
- R9: States are two-bit two's complement: 01 = +1, 00 = 0, 11 = −1, and 10 is never allowed. A valid command always moves a cell between 0 and ±1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a decision on the present inputs |
| vdc_in | input | NCELL*VW | Capacitor voltages, with cell c in bits [c*VW +: VW], signed |
| i_line | input | VW | AC line current, signed |
| v_ref | input | VW | Averaged converter voltage demand, signed |
| state_in | input | 2*NCELL | Present cell states, with cell c in bits [2c +: 2] |
| vd_drop | input | VW | Diode forward drop, unsigned |
| vq_drop | input | VW | Transistor forward drop, unsigned |
| rd_on | input | RW | Diode on-resistance, unsigned, RF fractional bits |
| rq_on | input | RW | Transistor on-resistance, unsigned, RF fractional bits |
| done | output | 1 | One-cycle pulse marking a ready command |
| cmd_valid | output | 1 | A cell commutates this period |
| cmd_cell | output | CW | Index of the cell that commutates |
| cmd_state | output | 2 | New state of that cell |
| cmd_tx | output | TW | Switching tick within the period, 0..TM |

## Verification
The directed cases target the places where each rule is easy to get wrong:
- Three equal capacitor voltages test the tie order. A design that broke ties the other way would command cell 2 instead of cell 0.
- A stack whose most imbalanced cell disagrees with the current checks that the block moves on to the next candidate. A selector that skipped the sign check would pick that worst cell.
- Small, huge and mid-range demands reach the TM clamp, the zero clamp and a real quotient. A missing clamp would wrap the tick, and a broken divider would give a quotient off by one or more.
- A snapshot with no losses and no demand must produce no command.
- A second `start` arriving during a division must leave the first answer unchanged.
- Random snapshots mix all three states with both current signs, so the mirrored negative-demand moves and the loss correction are compared against an independent model.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int AW = 48;
  typedef logic signed [AW-1:0] acc_t;
  typedef logic signed [1:0]    cst_t;

  function automatic acc_t f_sgn(acc_t x);
    if (x > 0) return acc_t'(1);
    if (x < 0) return acc_t'(-1);
    return '0;
  endfunction

  function automatic acc_t f_abs(acc_t x);
    return (x < 0) ? -x : x;
  endfunction

  // loss seen while the cell sits at zero output
  function automatic acc_t f_loss_zero(acc_t i, acc_t vd, acc_t vq, acc_t rd, acc_t rq, int unsigned rf);
    return f_sgn(i) * (vd + vq) - ((i * (rd + rq)) >>> rf);
  endfunction

  // loss while transistors conduct
  function automatic acc_t f_loss_pos(acc_t i, acc_t vq, acc_t rq, int unsigned rf);
    return -(acc_t'(2) * (vq + ((f_abs(i) * rq) >>> rf)));
  endfunction

  // loss while diodes conduct
  function automatic acc_t f_loss_neg(acc_t i, acc_t vd, acc_t rd, int unsigned rf);
    return acc_t'(2) * (vd + ((f_abs(i) * rd) >>> rf));
  endfunction

  function automatic acc_t f_eff(cst_t s, acc_t i, acc_t vdc, acc_t z, acc_t p, acc_t m);
    if (s == 2'sb00) return z;
    if ((s > 0) == (i >= 0)) return vdc + p;
    return vdc + m;
  endfunction

  function automatic acc_t f_term(cst_t s, acc_t v);
    if (s == 2'sb01) return v;
    if (s == 2'sb11) return -v;
    return '0;
  endfunction
endpackage

// File: rtl/dcb_rank.sv
module dcb_rank
  import dcb_pkg::*;
#(
  parameter int N  = 3,
  parameter int CW = 2
) (
  input  acc_t           mag   [N],
  output logic [CW-1:0]  order [N]
);
  logic [CW-1:0] pos [N];

  always_comb begin
    for (int a = 0; a < N; a++) begin
      pos[a] = '0;
      for (int b = 0; b < N; b++)
        if ((mag[b] > mag[a]) || ((mag[b] == mag[a]) && (b < a)))
          pos[a] = pos[a] + 1'b1;
    end
    for (int r = 0; r < N; r++) begin
      order[r] = '0;
      for (int a = 0; a < N; a++)
        if (pos[a] == CW'(r)) order[r] = CW'(a);
    end
  end
endmodule

// File: rtl/dcb_cand.sv
module dcb_cand
  import dcb_pkg::*;
(
  input  cst_t s,
  input  acc_t vdc,
  input  acc_t veff,
  input  acc_t err3,
  input  acc_t i,
  input  acc_t vref,
  input  acc_t others,
  input  acc_t z,
  input  acc_t p,
  input  acc_t m,
  output logic ok,
  output cst_t new_s,
  output acc_t xval
);
  acc_t demand, norm;
  logic agree;

  assign demand = vref - others + ((s == 2'sb00) ? z : acc_t'(0));
  assign norm   = (s == 2'sb00) ? vdc : veff;
  assign agree  = (err3 >= 0) == (i >= 0);

  always_comb begin
    ok    = 1'b0;
    new_s = s;
    xval  = '0;
    if (vdc > 0 && norm > 0) begin
      if (demand > 0) begin
        unique case (s)
          2'sb11: if (agree) begin ok = 1'b1; new_s = 2'sb00; end
          2'sb00: if (agree) begin
                    ok = 1'b1; new_s = 2'sb01;
                    xval = vdc - demand + ((i < 0) ? p : m);
                  end
          2'sb01: if (!agree && demand < norm) begin
                    ok = 1'b1; new_s = 2'sb00; xval = demand - z;
                  end
          default: ;
        endcase
      end else if (demand < 0) begin
        unique case (s)
          2'sb01: if (!agree) begin ok = 1'b1; new_s = 2'sb00; end
          2'sb00: if (!agree) begin
                    ok = 1'b1; new_s = 2'sb11;
                    xval = vdc + demand - ((i < 0) ? m : p);
                  end
          2'sb11: if (agree && demand > -norm) begin
                    ok = 1'b1; new_s = 2'sb00; xval = z - demand;
                  end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dcb_div.sv
module dcb_div #(
  parameter int NW = 25,
  parameter int DW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          fin,
  output logic [NW-1:0] quo
);
  localparam int CNTW = $clog2(NW + 1);
  localparam int PW   = NW + DW + 1;

  logic [NW-1:0]   nsh, num_q;
  logic [DW-1:0]   den_q;
  logic [DW:0]     rem;
  logic [CNTW-1:0] cnt;
  logic            busy;
  logic [DW:0]     rem_sh;
  logic [DW+1:0]   diff;
  logic            ge;

  assign rem_sh = {rem[DW-1:0], nsh[NW-1]};
  assign diff   = {1'b0, rem_sh} - {2'b00, den_q};
  assign ge     = ~diff[DW+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nsh <= '0; num_q <= '0; den_q <= '0; rem <= '0;
      quo <= '0; cnt <= '0; busy <= 1'b0; fin <= 1'b0;
    end else if (go) begin
      nsh <= num; num_q <= num; den_q <= den; rem <= '0;
      quo <= '0; cnt <= CNTW'(NW); busy <= 1'b1; fin <= 1'b0;
    end else if (busy) begin
      nsh <= nsh << 1;
      rem <= ge ? diff[DW:0] : rem_sh;
      quo <= {quo[NW-2:0], ge};
      cnt <= cnt - 1'b1;
      if (cnt == CNTW'(1)) begin
        busy <= 1'b0;
        fin  <= 1'b1;
      end
    end else begin
      fin <= 1'b0;
    end
  end

  // R7: quotient and remainder reproduce the dividend
  p_div_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> ((PW'(quo) * PW'(den_q) + PW'(rem)) == PW'(num_q)) && (rem < {1'b0, den_q}));
endmodule

// File: rtl/dclink_commutation_selector.sv
module dclink_commutation_selector
  import dcb_pkg::*;
#(
  parameter int NCELL = 3,
  parameter int VW    = 16,
  parameter int RW    = 12,
  parameter int RF    = 8,
  parameter int TM    = 1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [NCELL*VW-1:0]     vdc_in,
  input  logic signed [VW-1:0]    i_line,
  input  logic signed [VW-1:0]    v_ref,
  input  logic [2*NCELL-1:0]      state_in,
  input  logic [VW-1:0]           vd_drop,
  input  logic [VW-1:0]           vq_drop,
  input  logic [RW-1:0]           rd_on,
  input  logic [RW-1:0]           rq_on,
  output logic                    done,
  output logic                    cmd_valid,
  output logic [((NCELL>1)?$clog2(NCELL):1)-1:0] cmd_cell,
  output logic signed [1:0]       cmd_state,
  output logic [$clog2(TM+1)-1:0] cmd_tx
);
  localparam int CW = (NCELL > 1) ? $clog2(NCELL) : 1;
  localparam int TW = $clog2(TM + 1);
  localparam int DW = VW - 1;
  localparam int NW = DW + TW;

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_DIV, S_FIN} fsm_t;
  fsm_t fsm;

  logic signed [VW-1:0] vdc_q [NCELL];
  cst_t                 st_q  [NCELL];
  logic signed [VW-1:0] i_q, vref_q;
  logic [VW-1:0]        vd_q, vq_q;
  logic [RW-1:0]        rd_q, rq_q;
  logic [CW-1:0]        rcnt;

  acc_t a_i, a_ref, l_z, l_p, l_m, vsum, tsum;
  acc_t vdc_a [NCELL];
  acc_t eff   [NCELL];
  acc_t term  [NCELL];
  acc_t err3  [NCELL];
  acc_t mag   [NCELL];
  logic [CW-1:0] order [NCELL];

  assign a_i   = acc_t'(i_q);
  assign a_ref = acc_t'(vref_q);
  assign l_z   = f_loss_zero(a_i, acc_t'(vd_q), acc_t'(vq_q), acc_t'(rd_q), acc_t'(rq_q), RF);
  assign l_p   = f_loss_pos(a_i, acc_t'(vq_q), acc_t'(rq_q), RF);
  assign l_m   = f_loss_neg(a_i, acc_t'(vd_q), acc_t'(rd_q), RF);

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    assign vdc_a[c] = acc_t'(vdc_q[c]);
    assign eff[c]   = f_eff(st_q[c], a_i, vdc_a[c], l_z, l_p, l_m);
    assign term[c]  = f_term(st_q[c], eff[c]);
    assign err3[c]  = vsum - acc_t'(3) * vdc_a[c];
    assign mag[c]   = f_abs(err3[c]);
  end

  always_comb begin
    vsum = '0;
    tsum = '0;
    for (int c = 0; c < NCELL; c++) begin
      vsum = vsum + vdc_a[c];
      tsum = tsum + term[c];
    end
  end

  dcb_rank #(.N(NCELL), .CW(CW)) rank_i (.mag(mag), .order(order));

  // candidate under test this cycle
  logic [CW-1:0] cur;
  logic          c_ok;
  cst_t          c_new;
  acc_t          c_x;
  assign cur = order[rcnt];

  dcb_cand cand_i (
    .s(st_q[cur]), .vdc(vdc_a[cur]), .veff(eff[cur]), .err3(err3[cur]),
    .i(a_i), .vref(a_ref), .others(tsum - term[cur]),
    .z(l_z), .p(l_p), .m(l_m),
    .ok(c_ok), .new_s(c_new), .xval(c_x)
  );

  logic          x_low, x_high, div_go, div_fin;
  logic [NW-1:0] div_num, div_q;
  logic [DW-1:0] div_den;
  assign x_low   = (c_x <= 0);
  assign x_high  = (c_x >= vdc_a[cur]);
  assign div_go  = (fsm == S_EVAL) && c_ok && !x_low && !x_high;
  assign div_num = NW'(c_x[DW-1:0]) * NW'(TM);
  assign div_den = vdc_q[cur][DW-1:0];

  dcb_div #(.NW(NW), .DW(DW)) div_i (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
    .fin(div_fin), .quo(div_q)
  );

  assign done = (fsm == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm <= S_IDLE; rcnt <= '0;
      i_q <= '0; vref_q <= '0; vd_q <= '0; vq_q <= '0; rd_q <= '0; rq_q <= '0;
      for (int c = 0; c < NCELL; c++) begin vdc_q[c] <= '0; st_q[c] <= '0; end
      cmd_valid <= 1'b0; cmd_cell <= '0; cmd_state <= '0; cmd_tx <= '0;
    end else begin
      unique case (fsm)
        S_IDLE: if (start) begin
          for (int c = 0; c < NCELL; c++) begin
            vdc_q[c] <= vdc_in[c*VW +: VW];
            st_q[c]  <= state_in[2*c +: 2];
          end
          i_q <= i_line; vref_q <= v_ref;
          vd_q <= vd_drop; vq_q <= vq_drop; rd_q <= rd_on; rq_q <= rq_on;
          rcnt <= '0;
          fsm  <= S_EVAL;
        end
        S_EVAL: begin
          if (c_ok) begin
            cmd_valid <= 1'b1;
            cmd_cell  <= cur;
            cmd_state <= c_new;
            if (x_low) begin
              cmd_tx <= '0;
              fsm    <= S_FIN;
            end else if (x_high) begin
              cmd_tx <= TW'(TM);
              fsm    <= S_FIN;
            end else begin
              fsm <= S_DIV;
            end
          end else if (rcnt == CW'(NCELL - 1)) begin
            cmd_valid <= 1'b0; cmd_cell <= '0; cmd_state <= '0; cmd_tx <= '0;
            fsm <= S_FIN;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        S_DIV: if (div_fin) begin
          cmd_tx <= div_q[TW-1:0];
          fsm    <= S_FIN;
        end
        S_FIN: fsm <= S_IDLE;
        default: fsm <= S_IDLE;
      endcase
    end
  end

  // R7: the tick never leaves the period
  p_tx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cmd_valid) |-> (cmd_tx <= TW'(TM)));
  // R8: completion lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: moves are between zero and a rail
  p_state_adj_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cmd_valid) |-> ((cmd_state == 2'sb00) != (st_q[cmd_cell] == 2'sb00))
                            && (cmd_state != 2'sb10));
  // R6: an empty decision carries a zero command
  p_empty_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cmd_valid) |-> (cmd_tx == '0) && (cmd_state == 2'sb00) && (cmd_cell == '0));
  // R8: the latched snapshot stays put while a decision is in flight
  p_snapshot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm == S_DIV) |=> $stable(vref_q) && $stable(i_q));
endmodule

// File: tb/dclink_commutation_selector_tb_top.sv
module dclink_commutation_selector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCELL = 3;
  localparam int VW = 16;
  localparam int RW = 12;
  localparam int RF = 8;
  localparam int TM = 1000;
  localparam int NW = VW - 1 + $clog2(TM + 1);
  localparam int LAT_MAX = NCELL + NW + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NCELL*VW-1:0] vdc_in = '0;
  logic signed [VW-1:0] i_line = '0, v_ref = '0;
  logic [2*NCELL-1:0] state_in = '0;
  logic [VW-1:0] vd_drop = '0, vq_drop = '0;
  logic [RW-1:0] rd_on = '0, rq_on = '0;
  logic done, cmd_valid;
  logic [1:0] cmd_cell;
  logic signed [1:0] cmd_state;
  logic [9:0] cmd_tx;

  int checks = 0;
  int failures = 0;

  int m_vdc [NCELL];
  int m_st  [NCELL];
  int m_i, m_vref, m_vd, m_vq, m_rd, m_rq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dclink_commutation_selector #(.NCELL(NCELL), .VW(VW), .RW(RW), .RF(RF), .TM(TM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vdc_in(vdc_in), .i_line(i_line),
    .v_ref(v_ref), .state_in(state_in), .vd_drop(vd_drop), .vq_drop(vq_drop),
    .rd_on(rd_on), .rq_on(rq_on), .done(done), .cmd_valid(cmd_valid),
    .cmd_cell(cmd_cell), .cmd_state(cmd_state), .cmd_tx(cmd_tx)
  );

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint flr(longint a, int sh);
    longint p = longint'(1) << sh;
    if (a >= 0) return a / p;
    return -((-a + p - 1) / p);
  endfunction

  function automatic longint mabs(longint a);
    return (a < 0) ? -a : a;
  endfunction

  task automatic model(output int ec, output int es, output int etx, output bit ev, output string tag);
    longint sv, tot, z, p, m, d, n, x, ai, sg;
    longint e [NCELL];
    longint ef [NCELL];
    longint tr [NCELL];
    int ord [NCELL];
    bit used [NCELL];
    ai = mabs(m_i);
    sg = (m_i > 0) ? 1 : ((m_i < 0) ? -1 : 0);
    z = sg * (m_vd + m_vq) - flr(longint'(m_i) * (m_rd + m_rq), RF);
    p = -2 * (m_vq + flr(ai * m_rq, RF));
    m = 2 * (m_vd + flr(ai * m_rd, RF));
    sv = 0; tot = 0;
    for (int k = 0; k < NCELL; k++) sv += m_vdc[k];
    for (int k = 0; k < NCELL; k++) begin
      e[k] = sv - 3 * m_vdc[k];
      if (m_st[k] == 0) ef[k] = z;
      else if ((m_st[k] > 0) == (m_i >= 0)) ef[k] = m_vdc[k] + p;
      else ef[k] = m_vdc[k] + m;
      tr[k] = m_st[k] * ef[k];
      tot += tr[k];
      used[k] = 0;
    end
    for (int r = 0; r < NCELL; r++) begin
      int best = -1;
      for (int k = 0; k < NCELL; k++)
        if (!used[k] && (best < 0 || mabs(e[k]) > mabs(e[best]))) best = k;
      ord[r] = best;
      used[best] = 1;
    end
    ev = 0; ec = 0; es = 0; etx = 0; tag = "R6";
    for (int r = 0; r < NCELL; r++) begin
      int k = ord[r];
      bit same, ok;
      int ns;
      same = (e[k] >= 0) == (m_i >= 0);
      d = m_vref - (tot - tr[k]) + ((m_st[k] == 0) ? z : 0);
      n = (m_st[k] == 0) ? m_vdc[k] : ef[k];
      ok = 0; ns = m_st[k]; x = 0;
      if (m_vdc[k] > 0 && n > 0) begin
        if (d > 0) begin
          if (m_st[k] == -1 && same) begin ok = 1; ns = 0; end
          if (m_st[k] == 0 && same) begin ok = 1; ns = 1; x = m_vdc[k] - d + ((m_i < 0) ? p : m); end
          if (m_st[k] == 1 && !same && d < n) begin ok = 1; ns = 0; x = d - z; end
        end else if (d < 0) begin
          if (m_st[k] == 1 && !same) begin ok = 1; ns = 0; end
          if (m_st[k] == 0 && !same) begin ok = 1; ns = -1; x = m_vdc[k] + d - ((m_i < 0) ? m : p); end
          if (m_st[k] == -1 && same && d > -n) begin ok = 1; ns = 0; x = z - d; end
        end
      end
      if (ok) begin
        ev = 1; ec = k; es = ns;
        tag = (d > 0) ? "R4" : "R5";
        if (x <= 0) etx = 0;
        else if (x >= m_vdc[k]) etx = TM;
        else etx = int'((longint'(TM) * x) / m_vdc[k]);
        return;
      end
    end
  endtask

  task automatic drive();
    for (int k = 0; k < NCELL; k++) begin
      vdc_in[k*VW +: VW] = VW'(m_vdc[k]);
      state_in[2*k +: 2] = 2'(m_st[k]);
    end
    i_line = VW'(m_i); v_ref = VW'(m_vref);
    vd_drop = VW'(m_vd); vq_drop = VW'(m_vq);
    rd_on = RW'(m_rd); rq_on = RW'(m_rq);
  endtask

  task automatic run_op(input string lbl, input bit disturb);
    int ec, es, etx, lat;
    bit ev, ok;
    string tg;
    model(ec, es, etx, ev, tg);
    @(negedge clk);
    drive();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      m_vref = -m_vref; m_i = -m_i; m_st[0] = -m_st[0];
      drive();
      start = 1'b1;
    end
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
      start = 1'b0;
    end
    check(lat <= LAT_MAX, "R8", {lbl, " latency"}, lat, LAT_MAX);
    ok = (cmd_valid == ev) && (!ev || (cmd_cell == 2'(ec) && int'(cmd_state) == es && int'(cmd_tx) == etx));
    if (!ok)
      $display("FAIL %s %s cell=%0d/%0d state=%0d/%0d tx=%0d/%0d valid=%0d/%0d",
               disturb ? "R8" : tg, lbl, cmd_cell, ec, cmd_state, es, cmd_tx, etx, cmd_valid, ev);
    checks++;
    if (!ok) failures++;
    if (ev && !disturb) begin
      ok = ((es == 0) != (m_st[ec] == 0)) && (es >= -1) && (es <= 1);
      check(ok, "R9", {lbl, " adjacent move"}, es, m_st[ec]);
    end
    @(negedge clk);
    check(done == 1'b0, "R8", {lbl, " done width"}, done, 0);
  endtask

  task automatic set_flat(input int v0, input int v1, input int v2, input int i, input int vref, input int vd);
    m_vdc[0] = v0; m_vdc[1] = v1; m_vdc[2] = v2;
    m_st[0] = 0; m_st[1] = 0; m_st[2] = 0;
    m_i = i; m_vref = vref; m_vd = vd; m_vq = 0; m_rd = 0; m_rq = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 1'b0 && cmd_valid == 1'b0, "R1", "flags in reset", {done, cmd_valid}, 0);
    check(cmd_tx == '0 && cmd_cell == '0 && cmd_state == '0, "R1", "command in reset", cmd_tx, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && cmd_valid == 1'b0, "R1", "flags after reset", {done, cmd_valid}, 0);

    // R2 tie order, R7 clamp at TM
    set_flat(500, 500, 500, 10, 1, 5);
    run_op("tie_full", 1'b0);
    check(cmd_cell == 2'd0 && cmd_state == 2'sb01, "R2", "tie picks cell 0", cmd_cell, 0);
    check(cmd_tx == 10'(TM), "R7", "clamp to TM", cmd_tx, TM);

    // R7 clamp at zero
    set_flat(500, 500, 500, 10, 2000, 5);
    run_op("clamp_zero", 1'b0);
    check(cmd_tx == 10'd0 && cmd_valid, "R7", "clamp to zero", cmd_tx, 0);

    // R7 interior quotient
    set_flat(500, 500, 500, 10, 250, 5);
    run_op("mid_tick", 1'b0);
    check(cmd_tx == 10'd510, "R7", "interior tick", cmd_tx, 510);

    // R2 worst cell disagrees, next one is taken
    set_flat(500, 400, 620, 10, 250, 5);
    run_op("skip_worst", 1'b0);
    check(cmd_cell == 2'd1, "R2", "fallback cell", cmd_cell, 1);
    check(cmd_tx == 10'd387, "R7", "fallback tick", cmd_tx, 387);

    // R6 no candidate
    set_flat(500, 500, 500, 100, 0, 0);
    run_op("empty", 1'b0);
    check(cmd_valid == 1'b0 && cmd_tx == '0, "R6", "no command", cmd_valid, 0);

    // R3 heavy loss correction with mixed states
    m_vdc[0] = 520; m_vdc[1] = 480; m_vdc[2] = 505;
    m_st[0] = 1; m_st[1] = 1; m_st[2] = 0;
    m_i = -250; m_vref = 900; m_vd = 18; m_vq = 12; m_rd = 55; m_rq = 40;
    run_op("R3_losses", 1'b0);

    // R5 negative demand directed
    m_vdc[0] = 450; m_vdc[1] = 560; m_vdc[2] = 500;
    m_st[0] = 0; m_st[1] = -1; m_st[2] = 0;
    m_i = 120; m_vref = -900; m_vd = 6; m_vq = 4; m_rd = 20; m_rq = 20;
    run_op("R5_negative", 1'b0);

    // R8 start during a decision is ignored
    set_flat(500, 500, 500, 10, 250, 5);
    run_op("busy_start", 1'b1);

    for (int n = 0; n < 300; n++) begin
      for (int k = 0; k < NCELL; k++) begin
        m_vdc[k] = 300 + int'($urandom_range(400));
        m_st[k]  = int'($urandom_range(2)) - 1;
      end
      m_i    = int'($urandom_range(800)) - 400;
      m_vref = int'($urandom_range(4000)) - 2000;
      m_vd   = int'($urandom_range(20));
      m_vq   = int'($urandom_range(20));
      m_rd   = int'($urandom_range(60));
      m_rq   = int'($urandom_range(60));
      if (n % 25 == 0) m_vdc[1] = m_vdc[0];
      run_op("random", (n % 50) == 7);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule